// File: doc/BRIEF.md
# Bus Access Violation Capture Unit

This block watches a stream of access-violation events raised by the permission checkers in front of a large set of protected slave ports. Each event carries the slave index, the initiating master ID, the security domain, whether the access was a read or a write, and a 36-bit address. For every slave index the unit holds one sticky violation flag and one interrupt-suppress bit. The flags are packed 32 to a register word. The single interrupt line is raised while capture is on and at least one flag is set and not suppressed.

Slave indices are grouped in blocks of `GROUP_SIZE`. Each group keeps one detailed record in a small RAM. The record is the first violation seen since the group's pending flag was last cleared. Software does not read these records directly. It picks a pending group by writing a one-hot select word, starts a sync by writing 1 to the shift control register, and polls until that register reads 0x3. It then reads the two debug words, writes 0 to end the sync, and writes 1 to the group's pending bit to release the record slot.

Register reads return data one cycle after `reg_rd_en`. Register offsets: suppress words from 0x000, flag words from 0x400, debug words at 0x900 and 0x904, capture control at 0xF00, group pending at 0xF10, group select at 0xF14, shift control at 0xF20. Low address bits [1:0] must be zero for a hit. Unmapped reads return 0.

Top module: `busviol_capture`

## Requirements
- R1: After reset the interrupt is low, capture is off (control bit 31 reads 0), group pending, select, shift control and both debug words read 0, and every suppress word reads 1 in each bit that maps to a real index and 0 elsewhere.
- R2: An accepted event with index i < NUM_IDX sets bit i%32 of flag word i/32. Writing 1 to a flag bit clears it, and a set from an event in the same cycle wins. Events with index >= NUM_IDX are dropped, and flag bits beyond NUM_IDX always read 0.
- R3: Writing control with bit 31 set turns capture on, and writing bit 2 set turns it off; bit 2 wins if both are set. While capture is off, events change neither flags nor group pending bits.
- R4: The interrupt output is high one cycle after, and only while, capture is on and some flag bit is set with its suppress bit 0.
- R5: Suppress words read back as written, with bits that map to no index reading 0.
- R6: An accepted event sets the pending bit of group i/GROUP_SIZE in the group pending register. Writing 1 to a pending bit clears it.
- R7: A group's record holds the first accepted event since its pending bit was last clear. Later events in that group do not overwrite it until the bit is cleared.
- R8: Writing 1 to shift control makes it read 0x1 until the copy completes, then 0x3, within SYNC_LAT cycles of the write. Writing 0 makes it read 0.
- R9: After a sync of a pending group, debug word 0 holds master ID in [15:0], domain in [21:16], write flag in bit 22, read flag in bit 23 and address bits [35:32] in [27:24], with [31:28] zero. Debug word 1 holds address bits [31:0].
- R10: A sync whose select word is zero, or whose selected group is not pending, loads zeros into both debug words. With several select bits set, the lowest one is used.
- R11: The group select register reads back the value written, limited to NUM_GROUPS bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd_en |
| evt_valid | input | 1 | Violation event strobe |
| evt_idx | input | IDX_W | Slave index of the violation |
| evt_master | input | 16 | Master ID of the violating access |
| evt_domain | input | 6 | Domain ID of the violating access |
| evt_write | input | 1 | 1 for a write violation, 0 for a read |
| evt_addr | input | 36 | Violating address |
| irq_o | output | 1 | Registered violation interrupt |

## Verification
The hardest case to reach is a group that has taken several violations before it is serviced. The debug words must show the first of them and not the latest, and the slot must accept a fresh record only after the write-to-clear. The stimulus fires a seeded random burst of events, many of them in the same group and some beyond the last valid index. It then services groups lowest first through the full select, start, poll, stop, clear sequence and compares each record with the bench's first-event model. Directed steps cover an empty select, a non-pending group, a multi-bit select, the stop-bit priority and the boundary bits of the last word.

// File: rtl/bvc_pkg.sv
package bvc_pkg;
  localparam int MST_W  = 16;
  localparam int DOM_W  = 6;
  localparam int ADDR_W = 36;

  localparam logic [11:0] OFS_SUPP   = 12'h000;
  localparam logic [11:0] OFS_FLAG   = 12'h400;
  localparam logic [11:0] OFS_DBG0   = 12'h900;
  localparam logic [11:0] OFS_DBG1   = 12'h904;
  localparam logic [11:0] OFS_CTRL   = 12'hF00;
  localparam logic [11:0] OFS_PEND   = 12'hF10;
  localparam logic [11:0] OFS_SEL    = 12'hF14;
  localparam logic [11:0] OFS_SHIFT  = 12'hF20;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              wr;
    logic [DOM_W-1:0]  dom;
    logic [MST_W-1:0]  mst;
  } vio_rec_t;

  function automatic logic [31:0] pack_dbg0(vio_rec_t r);
    return {4'h0, r.addr[35:32], ~r.wr, r.wr, r.dom, r.mst};
  endfunction
endpackage

// File: rtl/bvc_flag_bank.sv
module bvc_flag_bank #(
  parameter int NUM_IDX   = 511,
  parameter int IDX_W     = 10,
  parameter int NUM_WORDS = (NUM_IDX + 31) / 32,
  parameter int WIDX_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cap_en,
  input  logic                    set_vld,
  input  logic [IDX_W-1:0]        set_idx,
  input  logic                    clr_wr,
  input  logic                    supp_wr,
  input  logic [WIDX_W-1:0]       wr_word,
  input  logic [31:0]             wr_data,
  output logic [NUM_WORDS*32-1:0] flag_flat,
  output logic [NUM_WORDS*32-1:0] supp_flat,
  output logic                    irq_q
);
  logic [IDX_W-1:0] set_word;
  assign set_word = set_idx >> 5;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam int NB = (NUM_IDX - w * 32 >= 32) ? 32 : (NUM_IDX - w * 32);
    localparam logic [32:0] ONE33 = 33'd1;
    localparam logic [32:0] USED33 = (ONE33 << NB) - 33'd1;
    localparam logic [31:0] USED = USED33[31:0];
    logic [31:0] set_bits;
    logic [31:0] clr_bits;
    logic        hit;

    assign hit      = (int'(wr_word) == w);
    assign set_bits = (set_vld && int'(set_word) == w) ? (32'd1 << set_idx[4:0]) : 32'd0;
    assign clr_bits = (clr_wr && hit) ? wr_data : 32'd0;

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_flat[w*32 +: 32] <= 32'd0;
        supp_flat[w*32 +: 32] <= USED;
      end else begin
        flag_flat[w*32 +: 32] <= ((flag_flat[w*32 +: 32] & ~clr_bits) | set_bits) & USED;
        if (supp_wr && hit)
          supp_flat[w*32 +: 32] <= wr_data & USED;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= cap_en && (|(flag_flat & ~supp_flat));
  end
endmodule

// File: rtl/bvc_record_store.sv
module bvc_record_store
  import bvc_pkg::*;
#(
  parameter int NUM_GROUPS = 16,
  parameter int GIDX_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_vld,
  input  logic [GIDX_W-1:0]     wr_grp,
  input  vio_rec_t              wr_rec,
  input  logic [NUM_GROUPS-1:0] pend_clr,
  input  logic                  rd_vld,
  input  logic [GIDX_W-1:0]     rd_grp,
  output logic [NUM_GROUPS-1:0] pend_q,
  output vio_rec_t              rd_rec_q,
  output logic                  rd_pend_q
);
  vio_rec_t mem [NUM_GROUPS];
  logic     slot_free;

  assign slot_free = !pend_q[wr_grp] || pend_clr[wr_grp];

  always_ff @(posedge clk) begin
    if (wr_vld && slot_free)
      mem[wr_grp] <= wr_rec;
    rd_rec_q <= mem[rd_grp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      rd_pend_q <= 1'b0;
    end else begin
      pend_q    <= (pend_q & ~pend_clr) |
                   (wr_vld ? (NUM_GROUPS'(1) << wr_grp) : '0);
      rd_pend_q <= rd_vld && pend_q[rd_grp];
    end
  end
endmodule

// File: rtl/bvc_shift_ctrl.sv
module bvc_shift_ctrl #(
  parameter int SYNC_LAT = 3,
  parameter int CNT_W    = $clog2(SYNC_LAT + 1) + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic stop,
  output logic capture,
  output logic run_q,
  output logic done_q
);
  logic [CNT_W-1:0] cnt_q;

  assign capture = run_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      run_q  <= 1'b1;
      done_q <= 1'b0;
      cnt_q  <= CNT_W'(SYNC_LAT);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/busviol_capture.sv
module busviol_capture
  import bvc_pkg::*;
#(
  parameter int NUM_IDX    = 511,
  parameter int GROUP_SIZE = 32,
  parameter int SYNC_LAT   = 3,
  parameter int IDX_W      = $clog2(NUM_IDX) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr_en,
  input  logic             reg_rd_en,
  input  logic [11:0]      reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             evt_valid,
  input  logic [IDX_W-1:0] evt_idx,
  input  logic [15:0]      evt_master,
  input  logic [5:0]       evt_domain,
  input  logic             evt_write,
  input  logic [35:0]      evt_addr,
  output logic             irq_o
);
  localparam int NUM_WORDS  = (NUM_IDX + 31) / 32;
  localparam int NUM_GROUPS = (NUM_IDX + GROUP_SIZE - 1) / GROUP_SIZE;
  localparam int GIDX_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam int WIDX_W     = 8;

  logic                    en_q;
  logic [NUM_GROUPS-1:0]   sel_q;
  logic [31:0]             dbg0_q, dbg1_q, rdata_q;
  logic                    accept;
  logic [GIDX_W-1:0]       evt_grp, sel_grp;
  logic                    sel_vld;
  logic [WIDX_W-1:0]       word_idx;
  logic                    in_supp, in_flag, aligned;
  logic [NUM_WORDS*32-1:0] flag_flat, supp_flat;
  logic [NUM_GROUPS-1:0]   pend, pend_clr;
  vio_rec_t                evt_rec, rd_rec;
  logic                    rd_pend, capture, run, done;
  logic                    wr_ctrl, wr_pend, wr_sel, wr_shift;

  assign accept   = evt_valid && en_q && (int'(evt_idx) < NUM_IDX);
  assign evt_grp  = GIDX_W'(int'(evt_idx) / GROUP_SIZE);
  assign evt_rec  = '{addr: evt_addr, wr: evt_write, dom: evt_domain, mst: evt_master};

  assign aligned  = (reg_addr[1:0] == 2'b00);
  assign word_idx = reg_addr[9:2];
  assign in_supp  = aligned && reg_addr[11:10] == 2'b00 && int'(word_idx) < NUM_WORDS;
  assign in_flag  = aligned && reg_addr[11:10] == 2'b01 && int'(word_idx) < NUM_WORDS;
  assign wr_ctrl  = reg_wr_en && reg_addr == OFS_CTRL;
  assign wr_pend  = reg_wr_en && reg_addr == OFS_PEND;
  assign wr_sel   = reg_wr_en && reg_addr == OFS_SEL;
  assign wr_shift = reg_wr_en && reg_addr == OFS_SHIFT;
  assign pend_clr = wr_pend ? reg_wdata[NUM_GROUPS-1:0] : '0;

  always_comb begin
    sel_grp = '0;
    sel_vld = 1'b0;
    for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
      if (sel_q[g]) begin
        sel_grp = GIDX_W'(g);
        sel_vld = 1'b1;
      end
    end
  end

  bvc_flag_bank #(
    .NUM_IDX(NUM_IDX), .IDX_W(IDX_W), .NUM_WORDS(NUM_WORDS), .WIDX_W(WIDX_W)
  ) u_flags (
    .clk(clk), .rst(rst), .cap_en(en_q),
    .set_vld(accept), .set_idx(evt_idx),
    .clr_wr(reg_wr_en && in_flag), .supp_wr(reg_wr_en && in_supp),
    .wr_word(word_idx), .wr_data(reg_wdata),
    .flag_flat(flag_flat), .supp_flat(supp_flat), .irq_q(irq_o)
  );

  bvc_record_store #(
    .NUM_GROUPS(NUM_GROUPS), .GIDX_W(GIDX_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .wr_vld(accept), .wr_grp(evt_grp), .wr_rec(evt_rec), .pend_clr(pend_clr),
    .rd_vld(sel_vld), .rd_grp(sel_grp),
    .pend_q(pend), .rd_rec_q(rd_rec), .rd_pend_q(rd_pend)
  );

  bvc_shift_ctrl #(
    .SYNC_LAT(SYNC_LAT)
  ) u_shift (
    .clk(clk), .rst(rst),
    .start(wr_shift && reg_wdata[0]), .stop(wr_shift && !reg_wdata[0]),
    .capture(capture), .run_q(run), .done_q(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      dbg0_q <= '0;
      dbg1_q <= '0;
    end else begin
      if (wr_ctrl) begin
        if (reg_wdata[2])       en_q <= 1'b0;
        else if (reg_wdata[31]) en_q <= 1'b1;
      end
      if (wr_sel) sel_q <= reg_wdata[NUM_GROUPS-1:0];
      if (capture) begin
        dbg0_q <= rd_pend ? pack_dbg0(rd_rec) : 32'd0;
        dbg1_q <= rd_pend ? rd_rec.addr[31:0] : 32'd0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd_en) begin
      if (in_supp)      rdata_q <= supp_flat[int'(word_idx)*32 +: 32];
      else if (in_flag) rdata_q <= flag_flat[int'(word_idx)*32 +: 32];
      else begin
        case (reg_addr)
          OFS_DBG0:  rdata_q <= dbg0_q;
          OFS_DBG1:  rdata_q <= dbg1_q;
          OFS_CTRL:  rdata_q <= {en_q, 31'd0};
          OFS_PEND:  rdata_q <= 32'(pend);
          OFS_SEL:   rdata_q <= 32'(sel_q);
          OFS_SHIFT: rdata_q <= {30'd0, done, run};
          default:   rdata_q <= 32'd0;
        endcase
      end
    end
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/bvc_checker.sv
module bvc_checker #(
  parameter int NUM_GROUPS = 16,
  parameter int SYNC_LAT   = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  irq_o,
  input logic                  en_q,
  input logic                  reg_wr_en,
  input logic [11:0]           reg_addr,
  input logic [31:0]           reg_wdata,
  input logic                  evt_valid,
  input logic [NUM_GROUPS-1:0] pend,
  input logic                  run,
  input logic                  done
);
  logic [15:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst)               wait_cnt <= '0;
    else if (run && !done) wait_cnt <= wait_cnt + 16'd1;
    else                   wait_cnt <= '0;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!irq_o && pend == '0));

  p_off_keeps_pend_r3: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !reg_wr_en) |=> $stable(pend));

  p_irq_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !irq_o);

  p_pend_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_addr == 12'hF10 && !evt_valid)
      |=> ((pend & $past(reg_wdata[NUM_GROUPS-1:0])) == '0));

  p_sync_bound_r8: assert property (@(posedge clk) disable iff (rst)
    wait_cnt <= 16'(SYNC_LAT));
endmodule

bind busviol_capture bvc_checker #(
  .NUM_GROUPS(NUM_GROUPS), .SYNC_LAT(SYNC_LAT)
) u_chk (
  .clk(clk), .rst(rst), .irq_o(irq_o), .en_q(en_q),
  .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .evt_valid(evt_valid), .pend(pend), .run(run), .done(done)
);

// File: tb/busviol_capture_test.sv
module busviol_capture_test;
  localparam int NIDX = 511;
  localparam int GSZ  = 32;
  localparam int NGRP = 16;
  localparam int NWRD = 16;
  localparam int LAT  = 3;
  localparam int IW   = 10;

  logic        clk = 0, rst = 1;
  logic        reg_wr_en = 0, reg_rd_en = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        evt_valid = 0, evt_write = 0;
  logic [IW-1:0] evt_idx = 0;
  logic [15:0] evt_master = 0;
  logic [5:0]  evt_domain = 0;
  logic [35:0] evt_addr = 0;
  logic        irq_o;

  int total = 0, bad = 0;
  logic [31:0] rd;

  logic        m_en;
  logic [31:0] m_flag [NWRD];
  logic [31:0] m_supp [NWRD];
  logic [NGRP-1:0] m_pend;
  logic [15:0] m_mst [NGRP];
  logic [5:0]  m_dom [NGRP];
  logic        m_wr  [NGRP];
  logic [35:0] m_adr [NGRP];

  always #2 clk = ~clk;

  busviol_capture uut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_valid(evt_valid), .evt_idx(evt_idx), .evt_master(evt_master),
    .evt_domain(evt_domain), .evt_write(evt_write), .evt_addr(evt_addr),
    .irq_o(irq_o)
  );

  function automatic logic [31:0] used_bits(int w);
    int nb = (NIDX - w * 32 >= 32) ? 32 : NIDX - w * 32;
    return (nb == 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 32'd1);
  endfunction

  function automatic logic [31:0] exp_dbg0(int g);
    return {4'h0, m_adr[g][35:32], ~m_wr[g], m_wr[g], m_dom[g], m_mst[g]};
  endfunction

  function automatic logic exp_irq();
    logic any = 0;
    for (int w = 0; w < NWRD; w++) any |= |(m_flag[w] & ~m_supp[w]);
    return m_en && any;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rdreg(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 0;
    d = reg_rdata;
  endtask

  task automatic fire(int idx, logic [15:0] mst, logic [5:0] dom, logic w, logic [35:0] a);
    @(negedge clk);
    evt_valid = 1; evt_idx = IW'(idx); evt_master = mst;
    evt_domain = dom; evt_write = w; evt_addr = a;
    @(negedge clk);
    evt_valid = 0;
    if (m_en && idx < NIDX) begin
      int g = idx / GSZ;
      m_flag[idx / 32][idx % 32] = 1'b1;
      if (!m_pend[g]) begin
        m_pend[g] = 1'b1;
        m_mst[g] = mst; m_dom[g] = dom; m_wr[g] = w; m_adr[g] = a;
      end
    end
  endtask

  task automatic do_sync(logic [31:0] sel);
    logic [31:0] v;
    wr(12'hF14, sel);
    wr(12'hF20, 32'd1);
    rdreg(12'hF20, v);
    check("R8 busy", v, 32'd1);
    for (int k = 0; k < 8 && v != 32'd3; k++) rdreg(12'hF20, v);
    check("R8 done", v, 32'd3);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    m_en = 0; m_pend = '0;
    for (int w = 0; w < NWRD; w++) begin m_flag[w] = 0; m_supp[w] = used_bits(w); end
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    rdreg(12'hF00, v); check("R1 ctrl", v, 0);
    rdreg(12'hF10, v); check("R1 pend", v, 0);
    rdreg(12'hF20, v); check("R1 shift", v, 0);
    rdreg(12'h900, v); check("R1 dbg0", v, 0);
    rdreg(12'h03C, v); check("R1 supp last", v, 32'h7FFF_FFFF);
    rdreg(12'h000, v); check("R1 supp first", v, 32'hFFFF_FFFF);

    // R3 disabled: events ignored
    fire(5, 16'h1, 6'h1, 1, 36'h1);
    rdreg(12'h400, v); check("R3 off flag", v, 0);
    rdreg(12'hF10, v); check("R3 off pend", v, 0);

    // R3 stop bit wins over enable bit
    wr(12'hF00, 32'h8000_0004);
    rdreg(12'hF00, v); check("R3 both", v, 0);
    wr(12'hF00, 32'h8000_0000); m_en = 1;
    rdreg(12'hF00, v); check("R3 enable", v, 32'h8000_0000);

    // R5 suppress word read/write, unused bits read 0
    wr(12'h03C, 32'hFFFF_FFFF);
    rdreg(12'h03C, v); check("R5 last word", v, 32'h7FFF_FFFF);
    wr(12'h004, 32'h1234_5678); m_supp[1] = 32'h1234_5678;
    rdreg(12'h004, v); check("R5 word1", v, 32'h1234_5678);

    // R2 boundary: index 510 valid, 511 dropped
    fire(511, 16'hAAAA, 6'h3, 0, 36'h0);
    fire(510, 16'hBEEF, 6'h2A, 0, 36'hF_1234_5678);
    rdreg(12'h43C, v); check("R2 last bits", v, 32'h4000_0000);
    rdreg(12'hF10, v); check("R6 pend g15", v, 32'h8000);
    check("R4 suppressed", {31'd0, irq_o}, {31'd0, exp_irq()});

    // R9/R7 service group 15 before random burst
    do_sync(32'h8000);
    rdreg(12'h900, v); check("R9 dbg0", v, exp_dbg0(15));
    rdreg(12'h904, v); check("R9 dbg1", v, m_adr[15][31:0]);
    wr(12'hF20, 0);
    rdreg(12'hF20, v); check("R8 stop", v, 0);
    rdreg(12'hF14, v); check("R11 sel", v, 32'h8000);
    wr(12'hF14, 32'hFFFF_0003);
    rdreg(12'hF14, v); check("R11 sel width", v, 32'h0003);

    // R10 empty select and non-pending group
    do_sync(32'h0);
    rdreg(12'h904, v); check("R10 empty dbg1", v, 0);
    rdreg(12'h900, v); check("R10 empty dbg0", v, 0);
    wr(12'hF20, 0);
    do_sync(32'h0002);
    rdreg(12'h900, v); check("R10 nonpend", v, 0);
    wr(12'hF20, 0);

    // random suppress pattern and event burst
    for (int w = 0; w < NWRD; w++) begin
      m_supp[w] = $urandom & used_bits(w);
      wr(12'(w * 4), m_supp[w]);
    end
    for (int n = 0; n < 60; n++)
      fire(int'($urandom % 540), 16'($urandom), 6'($urandom), 1'($urandom),
           {4'($urandom), 32'($urandom)});
    for (int w = 0; w < NWRD; w++) begin
      rdreg(12'(12'h400 + w * 4), v); check("R2 flags", v, m_flag[w]);
    end
    rdreg(12'hF10, v); check("R6 pend burst", v, 32'(m_pend));
    check("R4 irq burst", {31'd0, irq_o}, {31'd0, exp_irq()});

    // R7 service lowest pending first, first record wins
    for (int it = 0; it < NGRP && m_pend != 0; it++) begin
      int g = 0;
      while (!m_pend[g]) g++;
      do_sync(32'(1) << g);
      rdreg(12'h900, v); check("R7 dbg0", v, exp_dbg0(g));
      rdreg(12'h904, v); check("R7 dbg1", v, m_adr[g][31:0]);
      wr(12'hF20, 0);
      wr(12'hF10, 32'(1) << g); m_pend[g] = 0;
    end
    rdreg(12'hF10, v); check("R6 all clear", v, 0);

    // R10 multi-bit select uses lowest; new record after clear
    fire(40, 16'h7777, 6'h11, 1, 36'h2_0000_0040);
    fire(41, 16'h8888, 6'h12, 0, 36'h3_0000_0041);
    do_sync(32'h0006);
    rdreg(12'h900, v); check("R10 lowest sel", v, exp_dbg0(1));
    wr(12'hF20, 0);

    // R2/R4 clear all flags, interrupt drops
    for (int w = 0; w < NWRD; w++) begin
      wr(12'(12'h400 + w * 4), 32'hFFFF_FFFF); m_flag[w] = 0;
    end
    @(negedge clk);
    check("R4 irq cleared", {31'd0, irq_o}, 32'd0);
    rdreg(12'h404, v); check("R2 w1c", v, 0);

    // R4 unsuppressed flag raises irq, disable drops it
    wr(12'h000, 32'h0); m_supp[0] = 0;
    fire(3, 16'h1, 6'h1, 0, 36'h3);
    @(negedge clk);
    check("R4 irq raised", {31'd0, irq_o}, 32'd1);
    wr(12'hF00, 32'h4); m_en = 0;
    @(negedge clk);
    check("R4 irq off", {31'd0, irq_o}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule